// File: doc/BRIEF.md
# Per-Line Trigger Interrupt Controller

This block gathers up to 32 interrupt request lines into two processor-facing requests: a normal interrupt and a fast interrupt. Each line can sense either a level or an edge, and either polarity, so one controller can serve any mix of active-high, active-low, rising-edge and falling-edge sources. Every raw line is first retimed by a two-flop synchroniser. A captured edge is held in a per-line latch until software clears it by writing a one to that line's bit in the clear register.

Software reaches the controller through a simple request/write/address/data bus. The mask register gates lines out of the pending set. The route register sends chosen pending lines to the fast output instead of the normal one. A priority encoder continuously reports the lowest-numbered pending line and a flag that says whether any line is pending.

Top module: `trig_intc`

## Requirements
- R1: Register word addresses are 0 mode, 1 polarity, 2 mask, 3 fast-route, 4 edge-clear, 5 status, 6 pending. Address 7 reads zero. Read data appears on the rdata port the cycle after a read request. After reset the mask reads all ones and every other register reads zero. The irq, fiq and next-valid outputs are low after reset.
- R2: A line with mode bit 0 and polarity bit 0 shows in status exactly as its synchronised input: 1 while the input is high and 0 once the input is low again, with no memory.
- R3: A line with mode bit 0 and polarity bit 1 shows in status as the inverse of its synchronised input.
- R4: A line with mode bit 1 and polarity bit 0 sets its status bit on a 0-to-1 input transition. The bit stays set after the input returns low, until it is cleared.
- R5: A line with mode bit 1 and polarity bit 1 sets its status bit on a 1-to-0 input transition and not on a 0-to-1 transition.
- R6: Writing the edge-clear register clears the latched edge of every line whose data bit is 1, and leaves lines whose bit is 0 untouched. If an edge arrives in the same cycle as the clear, the edge wins. The edge-clear address reads zero.
- R7: A mask bit of 1 keeps that line out of irq, fiq and the next-pending outputs, while its status bit still shows the line.
- R8: The pending register reads status AND NOT mask.
- R9: The next_vld output is 1 exactly when some line is pending. next_idx then gives the lowest-numbered pending line, and next_idx is 0 when nothing is pending.
- R10: A pending line whose fast-route bit is 1 drives fiq; a pending line whose bit is 0 drives irq. With the route register at 0, fiq stays low.
- R11: An input change reaches status and the combinational outputs after exactly two clock edges for a level line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Raw interrupt lines, asynchronous |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data, one bit per line |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | OR of pending lines routed to normal interrupt |
| fiq_o | output | 1 | OR of pending lines routed to fast interrupt |
| next_idx_o | output | 5 | Lowest-numbered pending line |
| next_vld_o | output | 1 | Some line is pending |

## Verification
Lines are driven as held levels, as short pulses that return to idle before they are read back, and as falling transitions on lines configured for falling edges. Level lines are checked for following the input with no memory, and edge lines for holding the event, so a design that mixes up the mode bit is caught. Two lines pending together, with one of them then masked, show whether the encoder picks the lowest index and whether masking falls through to the next line. A clear written with zero bits and then with the line's bit shows that the register clears only the bits written as one. A route change between one and two fast lines checks that irq and fiq each switch independently.

// File: rtl/trig_intc_pkg.sv
package trig_intc_pkg;
  typedef enum logic [2:0] {
    REG_MODE  = 3'd0,
    REG_POL   = 3'd1,
    REG_MASK  = 3'd2,
    REG_ROUTE = 3'd3,
    REG_ECLR  = 3'd4,
    REG_STAT  = 3'd5,
    REG_PEND  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/trig_intc_sync.sv
module trig_intc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/trig_intc_line.sv
module trig_intc_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic mode_i,   // 1 = edge
  input  logic pol_i,    // 1 = low / falling
  input  logic clr_i,
  output logic status_o
);
  logic act, prev_q, latch_q, edge_hit;

  assign act      = sync_i ^ pol_i;
  assign edge_hit = mode_i & act & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= act;
      if (edge_hit)   latch_q <= 1'b1;  // event beats clear
      else if (clr_i) latch_q <= 1'b0;
    end
  end

  assign status_o = mode_i ? latch_q : act;

  assert_edge_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && !clr_i) |=> latch_q);
endmodule

// File: rtl/trig_intc_prio.sv
module trig_intc_prio #(
  parameter int unsigned N  = 32,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pend_i,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
  end

  assign vld_o = |pend_i;

  assert_pick_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> pend_i[idx_o]);
  assert_lowest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> ((pend_i & ((N'(1) << idx_o) - N'(1))) == '0));
  assert_idle_idx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |-> (idx_o == '0));
endmodule

// File: rtl/trig_intc.sv
module trig_intc
  import trig_intc_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  localparam int unsigned IW  = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] rdata_o,
  output logic            irq_o,
  output logic            fiq_o,
  output logic [IW-1:0]   next_idx_o,
  output logic            next_vld_o
);
  logic [NSRC-1:0] mode_q, pol_q, mask_q, route_q;
  logic [NSRC-1:0] src_sync, status, pend, clr, rd_val;
  logic wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '1;
      route_q <= '0;
    end else if (wr) begin
      unique case (addr_i)
        REG_MODE:  mode_q  <= wdata_i;
        REG_POL:   pol_q   <= wdata_i;
        REG_MASK:  mask_q  <= wdata_i;
        REG_ROUTE: route_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr = (wr && addr_i == REG_ECLR) ? wdata_i : '0;

  trig_intc_sync #(.W(NSRC), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(src_i), .q_o(src_sync)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_line
    trig_intc_line u_line (
      .clk_i, .rst_ni,
      .sync_i(src_sync[i]), .mode_i(mode_q[i]), .pol_i(pol_q[i]),
      .clr_i(clr[i]), .status_o(status[i])
    );
  end

  assign pend  = status & ~mask_q;
  assign irq_o = |(pend & ~route_q);
  assign fiq_o = |(pend & route_q);

  trig_intc_prio #(.N(NSRC)) u_prio (
    .clk_i, .rst_ni, .pend_i(pend), .idx_o(next_idx_o), .vld_o(next_vld_o)
  );

  always_comb begin
    unique case (addr_i)
      REG_MODE:  rd_val = mode_q;
      REG_POL:   rd_val = pol_q;
      REG_MASK:  rd_val = mask_q;
      REG_ROUTE: rd_val = route_q;
      REG_STAT:  rd_val = status;
      REG_PEND:  rd_val = pend;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_val;
  end

  assert_masked_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '1) |-> (!irq_o && !fiq_o && !next_vld_o));
  assert_fiq_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_q == '0) |-> !fiq_o);
  assert_clr_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == REG_ECLR) |=> (rdata_o == '0));
  assert_pend_drives_out_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_vld_o |-> (irq_o || fiq_o));
endmodule

// File: tb/trig_intc_test.sv
`timescale 1ns/1ps
module trig_intc_test;
  logic        clk = 0, rst_ni = 0;
  logic [31:0] src = '0;
  logic        req = 0, we = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq, vld;
  logic [4:0]  idx;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trig_intc uut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .fiq_o(fiq), .next_idx_o(idx), .next_vld_o(vld)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic restore();
    src = '0; settle();
    wr(3'd2, '1); wr(3'd0, '0); wr(3'd1, '0); wr(3'd3, '0);
    settle(); wr(3'd4, '1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", irq, 0); check("R1 fiq", fiq, 0); check("R1 vld", vld, 0);
    rd(3'd2, d); check("R1 mask", d, 32'hffff_ffff);
    rd(3'd0, d); check("R1 mode", d, 0);
    rd(3'd1, d); check("R1 pol", d, 0);
    rd(3'd3, d); check("R1 route", d, 0);
    rd(3'd5, d); check("R1 status", d, 0);
    rd(3'd7, d); check("R1 addr7", d, 0);
  endtask

  task automatic t_sync();
    wr(3'd2, ~32'h8);
    @(negedge clk); src[3] = 1;
    @(posedge clk); #1 check("R11 one edge", vld, 0);
    @(posedge clk); #1 check("R11 two edges", vld, 1);
    restore();
  endtask

  task automatic t_level_high();
    logic [31:0] d;
    wr(3'd2, ~32'h8);
    src[3] = 1; settle();
    rd(3'd5, d); check("R2 high", d, 32'h8);
    check("R9 idx3", idx, 3); check("R10 irq", irq, 1);
    src[3] = 0; settle();
    rd(3'd5, d); check("R2 no memory", d, 0);
    check("R2 irq low", irq, 0);
    restore();
  endtask

  task automatic t_level_low();
    logic [31:0] d;
    wr(3'd1, 32'h20); settle();
    rd(3'd5, d); check("R3 idle low", d, 32'h20);
    src[5] = 1; settle();
    rd(3'd5, d); check("R3 driven high", d, 0);
    restore();
  endtask

  task automatic t_edge_rise();
    logic [31:0] d;
    wr(3'd0, 32'h80); wr(3'd2, ~32'h80);
    src[7] = 1; repeat (3) @(negedge clk); src[7] = 0; settle();
    rd(3'd5, d); check("R4 latched", d, 32'h80);
    check("R4 irq", irq, 1);
    wr(3'd4, ~32'h80);
    rd(3'd5, d); check("R6 zero bit kept", d, 32'h80);
    wr(3'd4, 32'h80);
    rd(3'd5, d); check("R6 cleared", d, 0);
    rd(3'd4, d); check("R6 reads zero", d, 0);
    restore();
  endtask

  task automatic t_edge_fall();
    logic [31:0] d;
    src[9] = 1; settle();
    wr(3'd1, 32'h200); wr(3'd0, 32'h200); wr(3'd4, '1);
    rd(3'd5, d); check("R5 no event yet", d, 0);
    src[9] = 0; settle();
    rd(3'd5, d); check("R5 falling", d, 32'h200);
    wr(3'd4, 32'h200);
    src[9] = 1; settle();
    rd(3'd5, d); check("R5 rising ignored", d, 0);
    wr(3'd0, '0); src[9] = 0; settle();
    restore();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    src[12] = 1; settle();
    rd(3'd5, d); check("R7 status visible", d, 32'h1000);
    rd(3'd6, d); check("R8 masked pend", d, 0);
    check("R7 irq", irq, 0); check("R7 vld", vld, 0);
    wr(3'd2, ~32'h1000);
    rd(3'd6, d); check("R8 pend", d, 32'h1000);
    restore();
  endtask

  task automatic t_prio();
    src[6] = 1; src[20] = 1; settle();
    wr(3'd2, ~32'h0010_0040);
    check("R9 lowest", idx, 6); check("R9 vld", vld, 1);
    wr(3'd2, ~32'h0010_0000);
    check("R9 next", idx, 20);
    wr(3'd2, '1);
    check("R9 none vld", vld, 0); check("R9 none idx", idx, 0);
    restore();
  endtask

  task automatic t_fiq();
    src[6] = 1; src[20] = 1; settle();
    wr(3'd2, ~32'h0010_0040);
    check("R10 fiq off", fiq, 0);
    wr(3'd3, 32'h0010_0000);
    check("R10 fiq on", fiq, 1); check("R10 irq kept", irq, 1);
    wr(3'd3, 32'h0010_0040);
    check("R10 irq off", irq, 0); check("R10 fiq only", fiq, 1);
    restore();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset(); t_sync(); t_level_high(); t_level_low();
    t_edge_rise(); t_edge_fall(); t_mask(); t_prio(); t_fiq();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule